// File: doc/BRIEF.md
# In-Place Transpose Address Generator

This block produces the address stream for an external buffer that transposes a matrix in place while samples keep arriving. The buffer is assumed to have separate read and write ports. In every cycle that carries a valid sample, one stored sample is read out of a location and the new sample is written into that same location one cycle later. A single memory copy is therefore enough for each transpose stage. The matrix holds 2^log_rows × 2^log_cols points, so the total point count N is always a power of two. Square and rectangular shapes are both allowed.

The address of sample i in a frame is the log2(N)-bit index i rotated left by a running amount. That amount starts at zero. At every frame boundary it grows by log_rows in the forward direction, or by log_cols in the reverse direction, and it wraps modulo log2(N). As a result, the pattern repeats after at most log2(N) frames. Two instances with opposite direction settings can serve the outer and middle transposes of a two-stage long transform. The geometry and the direction are captured while reset is held. Reset is also the start control.

Top module: `tpa_addr_gen`

## Requirements
- R1: While rd_en is high, rd_addr equals the sample index i (counting 0 to N-1 within the current frame) rotated left by the current rotation amount within the low log_rows+log_cols bits, with all higher address bits zero.
- R2: The rotation amount is 0 after reset. When the last sample of a frame is read, it becomes (rotation + step) mod (log_rows+log_cols), where step is log_rows when rev_dir=0 and log_cols when rev_dir=1.
- R3: set_idx is 0 after reset and counts up by one at each frame boundary. It returns to 0 exactly when the new rotation amount is 0, so it never reaches log_rows+log_cols.
- R4: wr_en equals rd_en of the previous cycle. When wr_en is high, wr_addr equals rd_addr of the previous cycle, so each write lands one cycle after the read of the same location.
- R5: rd_en is high exactly when valid_in is high and rst is low. When rd_en is low, the sample index, the rotation and set_idx all hold their values.
- R6: frame_start is high in the cycle where the sample with index 0 is read, and frame_end is high in the cycle where the sample with index N-1 is read. Both are low when rd_en is low.
- R7: rst is synchronous and active high. It clears the sample index, the rotation, set_idx and wr_en, and it captures log_rows, log_cols and rev_dir. Changes on those three inputs while rst is low have no effect on the sequence.
- R8: Rectangular shapes (log_rows different from log_cols) and square shapes are both supported, for log_rows and log_cols each at least 1 with a sum of at most MAX_LOG_N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset and start; latches configuration |
| valid_in | input | 1 | A sample is moved this cycle |
| rev_dir | input | 1 | 0: step by log_rows, 1: step by log_cols |
| log_rows | input | LOG_W | log2 of the row count |
| log_cols | input | LOG_W | log2 of the column count |
| rd_addr | output | MAX_LOG_N | Read address for this cycle |
| rd_en | output | 1 | Read issued this cycle |
| wr_addr | output | MAX_LOG_N | Write address for this cycle |
| wr_en | output | 1 | Write issued this cycle |
| set_idx | output | LOG_W | Frame number within the repeating pattern |
| frame_start | output | 1 | First sample of a frame read |
| frame_end | output | 1 | Last sample of a frame read |

## Verification
The bench runs a 4×8 shape in both directions, so the rotation wraps through every residue of 5 and the set counter returns to zero after five frames. It also runs a square 8×8 shape, where the period is only two frames. A generator that took the modulo wrongly or picked the wrong step would drift off the expected addresses in the second or third frame. Gapped valid patterns expose a counter that advances on idle cycles, or a write delay keyed to the wrong cycle. Changing the geometry in the middle of a run shows whether the configuration leaks in outside reset. A reset in the middle of a frame shows whether the counter or the rotation survives a restart.

// File: rtl/tpa_pkg.sv
package tpa_pkg;

  typedef enum logic {
    DIR_FWD = 1'b0,
    DIR_REV = 1'b1
  } dir_e;

  // Rotate the low 'width' bits of v left by 'amt'; higher bits come out zero.
  function automatic logic [31:0] rotl_field(input logic [31:0] v, input int amt, input int width);
    logic [31:0] r;
    int          src;
    r = '0;
    for (int j = 0; j < 32; j++) begin
      if (j < width) begin
        src  = (j >= amt) ? (j - amt) : (j + width - amt);
        r[j] = v[src];
      end
    end
    return r;
  endfunction

  // Modular add with both operands already below the modulus.
  function automatic int next_rot(input int rot, input int step, input int width);
    int s;
    s = rot + step;
    return (s >= width) ? (s - width) : s;
  endfunction

  function automatic logic [31:0] low_mask(input int width);
    return (32'h1 << width) - 32'h1;
  endfunction

endpackage

// File: rtl/tpa_cfg_latch.sv
module tpa_cfg_latch #(
  parameter int LOG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rev_dir,
  input  logic [LOG_W-1:0] log_rows,
  input  logic [LOG_W-1:0] log_cols,
  output logic [LOG_W-1:0] log_n,
  output logic [LOG_W-1:0] step
);
  import tpa_pkg::*;

  logic [LOG_W-1:0] rows_q;
  logic [LOG_W-1:0] cols_q;
  dir_e             dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rows_q <= log_rows;
      cols_q <= log_cols;
      dir_q  <= dir_e'(rev_dir);
    end
  end

  assign log_n = rows_q + cols_q;
  assign step  = (dir_q == DIR_REV) ? cols_q : rows_q;

endmodule

// File: rtl/tpa_seq_counter.sv
module tpa_seq_counter #(
  parameter int AW    = 10,
  parameter int LOG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic [LOG_W-1:0] log_n,
  output logic [AW-1:0]    idx,
  output logic             last
);
  import tpa_pkg::*;

  logic [AW-1:0] mask;

  assign mask = AW'(low_mask(int'(log_n)));
  assign last = (idx == mask);

  always_ff @(posedge clk) begin
    if (rst)          idx <= '0;
    else if (advance) idx <= last ? '0 : idx + AW'(1);
  end

endmodule

// File: rtl/tpa_rot_accum.sv
module tpa_rot_accum #(
  parameter int LOG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrap,
  input  logic [LOG_W-1:0] log_n,
  input  logic [LOG_W-1:0] step,
  output logic [LOG_W-1:0] rot,
  output logic [LOG_W-1:0] set_num
);
  import tpa_pkg::*;

  logic [LOG_W-1:0] rot_nxt;

  assign rot_nxt = LOG_W'(next_rot(int'(rot), int'(step), int'(log_n)));

  always_ff @(posedge clk) begin
    if (rst) begin
      rot     <= '0;
      set_num <= '0;
    end else if (wrap) begin
      rot     <= rot_nxt;
      set_num <= (rot_nxt == '0) ? '0 : set_num + LOG_W'(1);
    end
  end

endmodule

// File: rtl/tpa_wr_delay.sv
module tpa_wr_delay #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
    end else begin
      wr_en   <= rd_en;
      wr_addr <= rd_addr;
    end
  end

endmodule

// File: rtl/tpa_addr_gen.sv
module tpa_addr_gen #(
  parameter  int MAX_LOG_N = 10,
  localparam int AW        = MAX_LOG_N,
  localparam int LOG_W     = $clog2(MAX_LOG_N + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_in,
  input  logic             rev_dir,
  input  logic [LOG_W-1:0] log_rows,
  input  logic [LOG_W-1:0] log_cols,
  output logic [AW-1:0]    rd_addr,
  output logic             rd_en,
  output logic [AW-1:0]    wr_addr,
  output logic             wr_en,
  output logic [LOG_W-1:0] set_idx,
  output logic             frame_start,
  output logic             frame_end
);
  import tpa_pkg::*;

  // named internal events, visible to the bound checker
  logic [LOG_W-1:0] log_n_q;
  logic [LOG_W-1:0] step_q;
  logic [AW-1:0]    seq_idx;
  logic             seq_last;
  logic             frame_wrap;
  logic [LOG_W-1:0] rot_amt;

  assign rd_en      = valid_in & ~rst;
  assign frame_wrap = rd_en & seq_last;

  tpa_cfg_latch #(.LOG_W(LOG_W)) u_cfg (
    .clk(clk), .rst(rst), .rev_dir(rev_dir),
    .log_rows(log_rows), .log_cols(log_cols),
    .log_n(log_n_q), .step(step_q)
  );

  tpa_seq_counter #(.AW(AW), .LOG_W(LOG_W)) u_cnt (
    .clk(clk), .rst(rst), .advance(rd_en), .log_n(log_n_q),
    .idx(seq_idx), .last(seq_last)
  );

  tpa_rot_accum #(.LOG_W(LOG_W)) u_rot (
    .clk(clk), .rst(rst), .wrap(frame_wrap), .log_n(log_n_q), .step(step_q),
    .rot(rot_amt), .set_num(set_idx)
  );

  assign rd_addr     = AW'(rotl_field(32'(seq_idx), int'(rot_amt), int'(log_n_q)));
  assign frame_start = rd_en & (seq_idx == '0);
  assign frame_end   = frame_wrap;

  tpa_wr_delay #(.AW(AW)) u_wr (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr)
  );

endmodule

// File: rtl/tpa_addr_gen_chk.sv
module tpa_addr_gen_chk #(
  parameter int AW    = 10,
  parameter int LOG_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             rd_en,
  input logic [AW-1:0]    rd_addr,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [LOG_W-1:0] set_idx,
  input logic             frame_start,
  input logic             frame_end,
  input logic [AW-1:0]    seq_idx,
  input logic [LOG_W-1:0] rot_amt,
  input logic [LOG_W-1:0] log_n_q
);

  a_r4_write_follows_read: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> (wr_en && wr_addr == $past(rd_addr)));

  a_r4_no_write_without_read: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !wr_en);

  a_r5_idle_holds_index: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> ($stable(seq_idx) && $stable(rot_amt) && $stable(set_idx)));

  a_r6_markers_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({frame_start, frame_end}));

  a_r6_end_then_index_zero: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (seq_idx == '0));

  a_r2_rot_in_range: assert property (@(posedge clk) disable iff (rst)
    rot_amt < log_n_q);

  a_r3_set_zero_iff_rot_zero: assert property (@(posedge clk) disable iff (rst)
    (rot_amt == '0) == (set_idx == '0));

endmodule

bind tpa_addr_gen tpa_addr_gen_chk #(.AW(AW), .LOG_W(LOG_W)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
  .wr_en(wr_en), .wr_addr(wr_addr), .set_idx(set_idx),
  .frame_start(frame_start), .frame_end(frame_end),
  .seq_idx(seq_idx), .rot_amt(rot_amt), .log_n_q(log_n_q)
);

// File: tb/sim_tpa_addr_gen.sv
`timescale 1ns/1ps
module sim_tpa_addr_gen;
  localparam int MAXL = 10;
  localparam int LW   = $clog2(MAXL + 1);

  typedef struct {
    bit      v;
    int      addr;
    bit      fs;
    bit      fe;
    int      set;
  } item_t;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            valid_in = 1'b0;
  logic            rev_dir = 1'b0;
  logic [LW-1:0]   log_rows = LW'(2);
  logic [LW-1:0]   log_cols = LW'(3);
  logic [MAXL-1:0] rd_addr, wr_addr;
  logic            rd_en, wr_en, frame_start, frame_end;
  logic [LW-1:0]   set_idx;

  always #4 clk = ~clk;

  tpa_addr_gen #(.MAX_LOG_N(MAXL)) u0 (
    .clk(clk), .rst(rst), .valid_in(valid_in), .rev_dir(rev_dir),
    .log_rows(log_rows), .log_cols(log_cols),
    .rd_addr(rd_addr), .rd_en(rd_en), .wr_addr(wr_addr), .wr_en(wr_en),
    .set_idx(set_idx), .frame_start(frame_start), .frame_end(frame_end)
  );

  int    checks = 0;
  int    errors = 0;
  string phase  = "";
  item_t q[$];
  bit    prev_v = 0;
  int    prev_addr = 0;

  // bench-side model state
  int m_L, m_step, m_i, m_r, m_set;

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s [%s] got %0d expected %0d", req, phase, got, exp);
    end
  endtask

  function automatic int model_addr(input int i, input int r, input int L);
    int mask;
    mask = (1 << L) - 1;
    return ((i << r) | (i >> (L - r))) & mask;
  endfunction

  // monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      check("R5 rd_en", int'(rd_en), int'(e.v));
      if (e.v) check("R1 rd_addr", int'(rd_addr), e.addr);
      check("R6 frame_start", int'(frame_start), int'(e.fs));
      check("R6 frame_end", int'(frame_end), int'(e.fe));
      check("R3 set_idx", int'(set_idx), e.set);
      check("R4 wr_en", int'(wr_en), int'(prev_v));
      if (prev_v) check("R4 wr_addr", int'(wr_addr), prev_addr);
      prev_v    = e.v;
      prev_addr = e.addr;
    end
  end

  // R7: reset captures configuration, clears state
  task automatic do_reset(input int rows, input int cols, input bit rev);
    @(posedge clk); #1;
    rst = 1'b1; valid_in = 1'b0;
    log_rows = LW'(rows); log_cols = LW'(cols); rev_dir = rev;
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst = 1'b0;
    prev_v = 0;
    m_L = rows + cols; m_step = rev ? cols : rows;
    m_i = 0; m_r = 0; m_set = 0;
    @(negedge clk);
    check("R7 reset rd_addr", int'(rd_addr), 0);
    check("R7 reset set_idx", int'(set_idx), 0);
    check("R7 reset wr_en", int'(wr_en), 0);
    check("R7 reset frame_start", int'(frame_start), 0);
  endtask

  // driver: one cycle, pushes the expected result, advances the model
  task automatic drive(input bit v);
    item_t e;
    @(posedge clk); #1;
    valid_in = v;
    e.v    = v;
    e.addr = model_addr(m_i, m_r, m_L);
    e.fs   = v && (m_i == 0);
    e.fe   = v && (m_i == (1 << m_L) - 1);
    e.set  = m_set;
    q.push_back(e);
    if (v) begin
      if (m_i == (1 << m_L) - 1) begin
        m_i = 0;
        m_r = (m_r + m_step) % m_L;
        m_set = (m_r == 0) ? 0 : m_set + 1;
      end else begin
        m_i++;
      end
    end
  endtask

  task automatic flush();
    @(posedge clk); #1;
    valid_in = 1'b0;
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  initial begin
    // R8 rectangular 4x8 forward: step 2 mod 5, period five frames (R2, R3)
    phase = "R8 rect fwd";
    do_reset(2, 3, 1'b0);
    for (int k = 0; k < 6 * 32; k++) drive(1'b1);
    flush();

    // rectangular reverse with idle gaps: step 3 mod 5 (R2, R5)
    phase = "R5 rev gaps";
    do_reset(2, 3, 1'b1);
    for (int k = 0; k < 5 * 32 * 3 / 2 + 20; k++) drive((k % 3) != 1);
    flush();

    // R8 square 8x8, period two frames; config wiggled mid-run (R7)
    phase = "R7 square cfg-ignore";
    do_reset(3, 3, 1'b0);
    for (int k = 0; k < 3 * 64; k++) begin
      if (k == 40) begin
        log_rows = LW'(1); log_cols = LW'(1); rev_dir = 1'b1;
      end
      drive((k % 7) != 3);
    end
    flush();

    // R7 reset in the middle of a frame restarts from index 0, rotation 0
    phase = "R7 midframe reset";
    do_reset(2, 2, 1'b0);
    for (int k = 0; k < 16 + 5; k++) drive(1'b1);
    flush();
    do_reset(2, 2, 1'b0);
    for (int k = 0; k < 2 * 16; k++) drive(1'b1);
    flush();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog [%s] got timeout expected completion", phase);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule